// File: doc/BRIEF.md
# Character-Tile VGA Display Controller

This block drives a VGA monitor with a 640x480 picture at 60 Hz from a 25 MHz pixel clock. Rather than storing a colour for every pixel, it draws a screen of character tiles. A tile map holds one 8-bit glyph index for each 8x16-pixel cell. A separate glyph store holds, for every glyph row, an 8-pixel on/off pattern and a foreground and a background colour. The picture area is 512 pixels wide and is centred in the 640 visible pixels, which gives a grid of 64 columns by 30 rows. Pixels outside that area are drawn black.

A processor changes the screen by writing glyph indices into the tile map, and glyph shapes into the glyph store, through write ports of their own. The display side reads both memories in a two-stage pipeline. The sync pulses are delayed through the same pipeline, so they stay aligned with the pixels. Writes never wait for the display and never disturb its timing.

Top module: `tile_vga_ctrl`

## Requirements
- R1: `hsyncN` goes low for 96 clocks in every 800-clock line. Within a line, pixel positions 0..639 are visible, 640..655 are front porch, 656..751 are the low pulse and 752..799 are back porch.
- R2: `vsyncN` goes low for 2 whole lines in every 525-line frame. Lines 0..479 are visible, 480..489 are front porch, 490..491 are the low pulse and 492..524 are back porch. `vsyncN` only changes at the start of a line (pixel position 0).
- R3: The colour outputs are zero at every position outside the visible 640x480 area. They are also zero inside it for pixel positions x < 64 or x >= 576.
- R4: At a window pixel (x, y), the tile map entry read is at address (y>>4)*64 + ((x-64)>>3).
- R5: The glyph word read for that pixel is at address index*16 + (y&15). Its fields are: bits [7:0] the pattern, [13:8] the foreground colour, [19:14] the background colour. Pattern bit 7-((x-64)&7) selects the colour: 1 gives the foreground, 0 the background. The 6-bit colour drives `red` from bits [5:4], `green` from [3:2] and `blue` from [1:0].
- R6: The colour and the sync levels for pixel position p of a line appear on the outputs two clocks after the pixel counters hold p. After reset is released, pixel 0 of line 0 is shown after the second rising edge.
- R7: A tile write with `tileWrEn` high stores `tileWrData` at `tileWrAddr`. Display reads from the next clock onward see the new value. A write to an address at or above 64*30 changes nothing.
- R8: A glyph write with `glyphWrEn` high stores `glyphWrData` at `glyphWrAddr`. Display reads from the next clock onward see the new value.
- R9: While `rstN` is low, `hsyncN` and `vsyncN` are high and the colour is zero. The pixel counters restart at position (0, 0).
- R10: If a tile write and a display read hit the same address on the same clock, the display read returns the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tileWrEn | input | 1 | Tile map write strobe |
| tileWrAddr | input | TILE_AW (11) | Tile map write address, row*64+column |
| tileWrData | input | 8 | Glyph index to store |
| glyphWrEn | input | 1 | Glyph store write strobe |
| glyphWrAddr | input | 12 | Glyph store address, index*16+row |
| glyphWrData | input | 20 | Glyph row word: pattern, foreground, background |
| hsyncN | output | 1 | Horizontal sync, active low |
| vsyncN | output | 1 | Vertical sync, active low |
| red | output | 2 | Red intensity |
| green | output | 2 | Green intensity |
| blue | output | 2 | Blue intensity |

## Verification
Some properties are checked at every clock. These are: the hsync pulse width and line period, the vsync pulse width, vsync changing only at a line start, and black colour during either sync pulse.

Other behaviour needs a reference model, which the bench's scenarios provide:
- the tile and glyph addressing;
- pattern bit order and the foreground/background choice;
- the black margins of the window;
- the two-clock alignment;
- writes that land mid-frame, including ones out of range and ones that collide with a display read.

The vertical frame is shortened through parameters so that several frames fit in one run. The horizontal timing is kept at its default.

// File: rtl/tile_vga_pkg.sv
package tile_vga_pkg;
  localparam int GLYPH_W = 8;
  localparam int GLYPH_H = 16;
  localparam int SUBX_W  = $clog2(GLYPH_W);
  localparam int SUBY_W  = $clog2(GLYPH_H);
  localparam int COLOR_W = 6;
  localparam int IDX_W   = 8;
  localparam int PAT_W   = GLYPH_W;
  localparam int WORD_W  = PAT_W + 2 * COLOR_W;

  // Per-pixel strobes handed from the timing control to the datapath
  typedef struct packed {
    logic              bright;
    logic              inWin;
    logic              hsyncAct;
    logic              vsyncAct;
    logic [SUBX_W-1:0] subX;
    logic [SUBY_W-1:0] subY;
  } pixStrobe_t;

  localparam pixStrobe_t BLANK_STROBE = '0;
endpackage

// File: rtl/tile_vga_timing.sv
module tile_vga_timing
  import tile_vga_pkg::*;
#(
  parameter int H_VIS   = 640,
  parameter int H_FP    = 16,
  parameter int H_SYNC  = 96,
  parameter int H_BP    = 48,
  parameter int V_VIS   = 480,
  parameter int V_FP    = 10,
  parameter int V_SYNC  = 2,
  parameter int V_BP    = 33,
  parameter int WIN_X0  = 64,
  parameter int WIN_W   = 512,
  parameter int COLS    = 64,
  parameter int TILE_AW = 11
) (
  input  logic               clk,
  input  logic               rstN,
  output pixStrobe_t         strobe,
  output logic [TILE_AW-1:0] tileRdAddr
);
  localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int HCW = $clog2(H_TOTAL);
  localparam int VCW = $clog2(V_TOTAL);

  localparam logic [HCW-1:0] H_LAST   = HCW'(H_TOTAL - 1);
  localparam logic [HCW-1:0] H_VISEND = HCW'(H_VIS);
  localparam logic [HCW-1:0] HS_BEG   = HCW'(H_VIS + H_FP);
  localparam logic [HCW-1:0] HS_END   = HCW'(H_VIS + H_FP + H_SYNC);
  localparam logic [HCW-1:0] WIN_BEG  = HCW'(WIN_X0);
  localparam logic [HCW-1:0] WIN_END  = HCW'(WIN_X0 + WIN_W);
  localparam logic [VCW-1:0] V_LAST   = VCW'(V_TOTAL - 1);
  localparam logic [VCW-1:0] V_VISEND = VCW'(V_VIS);
  localparam logic [VCW-1:0] VS_BEG   = VCW'(V_VIS + V_FP);
  localparam logic [VCW-1:0] VS_END   = VCW'(V_VIS + V_FP + V_SYNC);

  logic [HCW-1:0] hCnt;
  logic [VCW-1:0] vCnt;
  logic [HCW-1:0] relX;
  logic           lineEnd;

  assign lineEnd = (hCnt == H_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (lineEnd) begin
      hCnt <= '0;
      vCnt <= (vCnt == V_LAST) ? '0 : vCnt + 1'b1;
    end else begin
      hCnt <= hCnt + 1'b1;
    end
  end

  assign relX = hCnt - WIN_BEG;

  always_comb begin
    strobe.bright   = (hCnt < H_VISEND) && (vCnt < V_VISEND);
    strobe.inWin    = (hCnt >= WIN_BEG) && (hCnt < WIN_END);
    strobe.hsyncAct = (hCnt >= HS_BEG) && (hCnt < HS_END);
    strobe.vsyncAct = (vCnt >= VS_BEG) && (vCnt < VS_END);
    strobe.subX     = relX[SUBX_W-1:0];
    strobe.subY     = vCnt[SUBY_W-1:0];
    if (strobe.bright && strobe.inWin)
      tileRdAddr = TILE_AW'(int'(vCnt >> SUBY_W) * COLS + int'(relX >> SUBX_W));
    else
      tileRdAddr = '0;
  end
endmodule

// File: rtl/tile_vga_datapath.sv
module tile_vga_datapath
  import tile_vga_pkg::*;
#(
  parameter int TILE_DEPTH = 1920,
  parameter int TILE_AW    = 11
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  pixStrobe_t                strobe,
  input  logic [TILE_AW-1:0]        tileRdAddr,
  input  logic                      tileWrEn,
  input  logic [TILE_AW-1:0]        tileWrAddr,
  input  logic [IDX_W-1:0]          tileWrData,
  input  logic                      glyphWrEn,
  input  logic [IDX_W+SUBY_W-1:0]   glyphWrAddr,
  input  logic [WORD_W-1:0]         glyphWrData,
  output logic                      hsyncN,
  output logic                      vsyncN,
  output logic [COLOR_W-1:0]        pixColour
);
  localparam int GLYPH_AW    = IDX_W + SUBY_W;
  localparam int GLYPH_DEPTH = 1 << GLYPH_AW;
  localparam logic [TILE_AW:0] TILE_LIMIT = (TILE_AW + 1)'(TILE_DEPTH);

  logic [IDX_W-1:0]  tileMem  [TILE_DEPTH];
  logic [WORD_W-1:0] glyphMem [GLYPH_DEPTH];

  // stage 1: tile index fetched, strobes held
  pixStrobe_t        s1Strb;
  logic [IDX_W-1:0]  tileIdx;
  // stage 2: glyph word fetched, strobes held
  logic              s2Bright, s2InWin, s2Hs, s2Vs;
  logic [SUBX_W-1:0] s2SubX;
  logic [WORD_W-1:0] glyphWord;

  logic              tileWrOk;
  logic [PAT_W-1:0]  pattern;
  logic [COLOR_W-1:0] fgColour, bgColour;

  assign tileWrOk = tileWrEn && ({1'b0, tileWrAddr} < TILE_LIMIT);

  always_ff @(posedge clk) begin
    if (tileWrOk) tileMem[tileWrAddr] <= tileWrData;
    tileIdx <= tileMem[tileRdAddr];
  end

  always_ff @(posedge clk) begin
    if (glyphWrEn) glyphMem[glyphWrAddr] <= glyphWrData;
    glyphWord <= glyphMem[{tileIdx, s1Strb.subY}];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Strb   <= BLANK_STROBE;
      s2Bright <= 1'b0;
      s2InWin  <= 1'b0;
      s2Hs     <= 1'b0;
      s2Vs     <= 1'b0;
      s2SubX   <= '0;
    end else begin
      s1Strb   <= strobe;
      s2Bright <= s1Strb.bright;
      s2InWin  <= s1Strb.inWin;
      s2Hs     <= s1Strb.hsyncAct;
      s2Vs     <= s1Strb.vsyncAct;
      s2SubX   <= s1Strb.subX;
    end
  end

  assign pattern  = glyphWord[PAT_W-1:0];
  assign fgColour = glyphWord[PAT_W +: COLOR_W];
  assign bgColour = glyphWord[PAT_W+COLOR_W +: COLOR_W];

  always_comb begin
    if (s2Bright && s2InWin)
      pixColour = pattern[SUBX_W'(GLYPH_W - 1) - s2SubX] ? fgColour : bgColour;
    else
      pixColour = '0;
  end

  assign hsyncN = ~s2Hs;
  assign vsyncN = ~s2Vs;
endmodule

// File: rtl/tile_vga_ctrl.sv
module tile_vga_ctrl
  import tile_vga_pkg::*;
#(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  parameter int WIN_X0 = 64,
  parameter int WIN_W  = 512,
  localparam int COLS       = WIN_W / GLYPH_W,
  localparam int ROWS       = V_VIS / GLYPH_H,
  localparam int TILE_DEPTH = COLS * ROWS,
  localparam int TILE_AW    = $clog2(TILE_DEPTH)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    tileWrEn,
  input  logic [TILE_AW-1:0]      tileWrAddr,
  input  logic [IDX_W-1:0]        tileWrData,
  input  logic                    glyphWrEn,
  input  logic [IDX_W+SUBY_W-1:0] glyphWrAddr,
  input  logic [WORD_W-1:0]       glyphWrData,
  output logic                    hsyncN,
  output logic                    vsyncN,
  output logic [1:0]              red,
  output logic [1:0]              green,
  output logic [1:0]              blue
);
  pixStrobe_t         strobe;
  logic [TILE_AW-1:0] tileRdAddr;
  logic [COLOR_W-1:0] pixColour;

  tile_vga_timing #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .WIN_X0(WIN_X0), .WIN_W(WIN_W), .COLS(COLS), .TILE_AW(TILE_AW)
  ) timing_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .tileRdAddr(tileRdAddr)
  );

  tile_vga_datapath #(
    .TILE_DEPTH(TILE_DEPTH), .TILE_AW(TILE_AW)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .tileRdAddr(tileRdAddr),
    .tileWrEn(tileWrEn), .tileWrAddr(tileWrAddr), .tileWrData(tileWrData),
    .glyphWrEn(glyphWrEn), .glyphWrAddr(glyphWrAddr), .glyphWrData(glyphWrData),
    .hsyncN(hsyncN), .vsyncN(vsyncN), .pixColour(pixColour)
  );

  assign red   = pixColour[5:4];
  assign green = pixColour[3:2];
  assign blue  = pixColour[1:0];
endmodule

// File: rtl/tile_vga_checker.sv
module tile_vga_checker #(
  parameter int H_TOTAL  = 800,
  parameter int H_SYNC   = 96,
  parameter int H_PRESYN = 656,
  parameter int V_SYNC   = 2
) (
  input logic       clk,
  input logic       rstN,
  input logic       hsyncN,
  input logic       vsyncN,
  input logic [5:0] colour
);
  int   hLow, vLow, sinceFall;
  logic seenFall, prevH, prevV;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hLow <= 0; vLow <= 0; sinceFall <= 0;
      seenFall <= 1'b0; prevH <= 1'b1; prevV <= 1'b1;
    end else begin
      prevH <= hsyncN;
      prevV <= vsyncN;
      hLow  <= hsyncN ? 0 : hLow + 1;
      vLow  <= vsyncN ? 0 : vLow + 1;
      if (prevH && !hsyncN) begin
        sinceFall <= 1;
        seenFall  <= 1'b1;
      end else if (sinceFall < H_TOTAL) begin
        sinceFall <= sinceFall + 1;
      end
    end
  end

  a_r1_hsync_width: assert property (@(posedge clk) disable iff (!rstN)
    (!prevH && hsyncN) |-> (hLow == H_SYNC))
    else $error("hsync pulse width wrong");

  a_r1_line_period: assert property (@(posedge clk) disable iff (!rstN)
    (prevH && !hsyncN && seenFall) |-> (sinceFall == H_TOTAL))
    else $error("line period wrong");

  a_r2_vsync_width: assert property (@(posedge clk) disable iff (!rstN)
    (!prevV && vsyncN) |-> (vLow == V_SYNC * H_TOTAL))
    else $error("vsync pulse width wrong");

  a_r2_vsync_line_start: assert property (@(posedge clk) disable iff (!rstN)
    ((vsyncN != prevV) && seenFall) |-> (sinceFall == H_TOTAL - H_PRESYN))
    else $error("vsync changed away from line start");

  a_r3_dark_in_hsync: assert property (@(posedge clk) disable iff (!rstN)
    !hsyncN |-> (colour == 6'd0))
    else $error("colour during hsync");

  a_r3_dark_in_vsync: assert property (@(posedge clk) disable iff (!rstN)
    !vsyncN |-> (colour == 6'd0))
    else $error("colour during vsync");
endmodule

bind tile_vga_ctrl tile_vga_checker #(
  .H_TOTAL(H_VIS + H_FP + H_SYNC + H_BP),
  .H_SYNC(H_SYNC),
  .H_PRESYN(H_VIS + H_FP),
  .V_SYNC(V_SYNC)
) chk_i (
  .clk(clk), .rstN(rstN), .hsyncN(hsyncN), .vsyncN(vsyncN),
  .colour({red, green, blue})
);

// File: tb/tile_vga_ctrl_tb_top.sv
module tile_vga_ctrl_tb_top;
  localparam int HV = 640, HFP = 16, HS = 96, HBP = 48;
  localparam int VV = 48,  VFP = 2,  VS = 2,  VBP = 3;
  localparam int HT = HV + HFP + HS + HBP;
  localparam int VT = VV + VFP + VS + VBP;
  localparam int TDEPTH = 64 * (VV / 16);
  localparam int TAW = $clog2(TDEPTH);
  localparam int GDEPTH = 4096;
  localparam int RUN = 100000;

  logic clk = 1'b0;
  logic rstN;
  logic tileWrEn, glyphWrEn;
  logic [TAW-1:0] tileWrAddr;
  logic [7:0] tileWrData;
  logic [11:0] glyphWrAddr;
  logic [19:0] glyphWrData;
  logic hsyncN, vsyncN;
  logic [1:0] red, green, blue;

  always #5 clk = ~clk;

  tile_vga_ctrl #(
    .H_VIS(HV), .H_FP(HFP), .H_SYNC(HS), .H_BP(HBP),
    .V_VIS(VV), .V_FP(VFP), .V_SYNC(VS), .V_BP(VBP)
  ) dut_i (
    .clk(clk), .rstN(rstN),
    .tileWrEn(tileWrEn), .tileWrAddr(tileWrAddr), .tileWrData(tileWrData),
    .glyphWrEn(glyphWrEn), .glyphWrAddr(glyphWrAddr), .glyphWrData(glyphWrData),
    .hsyncN(hsyncN), .vsyncN(vsyncN), .red(red), .green(green), .blue(blue)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference model
  int tileM [TDEPTH];
  int glyphM [GDEPTH];
  int mx, my, edgesRun;
  int p1b, p1w, p1hs, p1vs, p1sx, p1sy, p1idx;
  int p2b, p2w, p2hs, p2vs, p2sx, p2word;

  function automatic int glyphGen(int a);
    int pat, fg, bg;
    pat = (a * 73 + (a >> 3) * 29) & 255;
    fg  = ((a * 5) & 63) | 1;
    bg  = ((a * 11 + 7) & 63) | 32;
    return pat | (fg << 8) | (bg << 14);
  endfunction

  function automatic int expColour();
    int pat, bitv;
    if (!(p2b != 0 && p2w != 0)) return 0;
    pat  = p2word & 255;
    bitv = (pat >> (7 - p2sx)) & 1;
    return bitv != 0 ? ((p2word >> 8) & 63) : ((p2word >> 14) & 63);
  endfunction

  task automatic modelStep();
    int ta;
    if (!rstN) begin
      mx = 0; my = 0; edgesRun = 0;
      p1b = 0; p1w = 0; p1hs = 0; p1vs = 0; p1sx = 0; p1sy = 0; p1idx = 0;
      p2b = 0; p2w = 0; p2hs = 0; p2vs = 0; p2sx = 0; p2word = 0;
    end else begin
      edgesRun++;
      p2b = p1b; p2w = p1w; p2hs = p1hs; p2vs = p1vs; p2sx = p1sx;
      p2word = glyphM[p1idx * 16 + p1sy];
      p1b  = (mx < HV && my < VV) ? 1 : 0;
      p1w  = (mx >= 64 && mx < 576) ? 1 : 0;
      p1hs = (mx >= HV + HFP && mx < HV + HFP + HS) ? 1 : 0;
      p1vs = (my >= VV + VFP && my < VV + VFP + VS) ? 1 : 0;
      p1sx = mx & 7;
      p1sy = my % 16;
      ta   = (p1b != 0 && p1w != 0) ? (my / 16) * 64 + (mx - 64) / 8 : 0;
      p1idx = tileM[ta];
      if (mx == HT - 1) begin
        mx = 0;
        my = (my == VT - 1) ? 0 : my + 1;
      end else mx++;
    end
    if (tileWrEn && int'(tileWrAddr) < TDEPTH) tileM[tileWrAddr] = int'(tileWrData);
    if (glyphWrEn) glyphM[glyphWrAddr] = int'(glyphWrData);
  endtask

  task automatic compareAll();
    int ec, ac;
    ec = expColour();
    ac = int'({red, green, blue});
    checks++;
    if (int'(hsyncN) != 1 - p2hs) begin
      fails++;
      $display("FAIL %s hsyncN act=%0d exp=%0d", rstN ? "R1" : "R9", hsyncN, 1 - p2hs);
    end
    checks++;
    if (int'(vsyncN) != 1 - p2vs) begin
      fails++;
      $display("FAIL %s vsyncN act=%0d exp=%0d", rstN ? "R2" : "R9", vsyncN, 1 - p2vs);
    end
    checks++;
    if (ac != ec) begin
      fails++;
      if (!rstN) $display("FAIL R9 colour in reset act=%0d exp=%0d", ac, ec);
      else if (ec == 0 && !(p2b != 0 && p2w != 0))
        $display("FAIL R3 blank colour act=%0d exp=%0d", ac, ec);
      else $display("FAIL R4/R5/R7/R8/R10 pixel colour act=%0d exp=%0d", ac, ec);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    modelStep();
    compareAll();
  endtask

  initial begin
    rstN = 1'b0;
    tileWrEn = 1'b0; tileWrAddr = '0; tileWrData = '0;
    glyphWrEn = 1'b0; glyphWrAddr = '0; glyphWrData = '0;
    for (int i = 0; i < TDEPTH; i++) tileM[i] = 0;
    for (int i = 0; i < GDEPTH; i++) glyphM[i] = 0;
    // R9: memories loaded while reset holds the outputs idle
    for (int i = 0; i < GDEPTH; i++) begin
      tileWrEn    = (i < TDEPTH);
      tileWrAddr  = TAW'(i);
      tileWrData  = 8'((i * 7 + 3) & 255);
      glyphWrEn   = 1'b1;
      glyphWrAddr = 12'(i);
      glyphWrData = 20'(glyphGen(i));
      tick();
    end
    tileWrEn = 1'b0; glyphWrEn = 1'b0;
    tick();
    rstN = 1'b1;
    for (int n = 0; n < RUN; n++) begin
      tick();
      // R6: pixel 63 shows after edge 65 as black, pixel 64 after edge 66 lit
      if (edgesRun == 65) begin
        checks++;
        if ({red, green, blue} != 6'd0) begin
          fails++;
          $display("FAIL R6 pixel 63 act=%0d exp=0", {red, green, blue});
        end
      end
      if (edgesRun == 66) begin
        checks++;
        if ({red, green, blue} == 6'd0) begin
          fails++;
          $display("FAIL R6 pixel 64 act=0 exp=nonzero");
        end
      end
      tileWrEn = 1'b0; glyphWrEn = 1'b0;
      if (n > 200) begin
        if ($urandom % 8 == 0) begin
          tileWrEn   = 1'b1;
          tileWrAddr = TAW'($urandom % 256); // R7: includes out-of-range addresses
          tileWrData = 8'($urandom % 256);
        end
        // R10: write the address the display reads at the coming edge
        if (n % 64 == 0 && mx >= 64 && mx < 576 && my < VV) begin
          tileWrEn   = 1'b1;
          tileWrAddr = TAW'((my / 16) * 64 + (mx - 64) / 8);
          tileWrData = 8'($urandom % 256);
        end
        if ($urandom % 16 == 0) begin
          glyphWrEn   = 1'b1; // R8
          glyphWrAddr = 12'($urandom % 4096);
          glyphWrData = 20'(int'($urandom % 256) | ((int'($urandom % 64) | 1) << 8)
                          | ((int'($urandom % 64) | 32) << 14));
        end
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule